// File: doc/BRIEF.md
# Serial Motor Configuration Interface

This block is the write-only configuration port of a multi-channel motor driver. A host shifts an 8-bit word in over three wires: a serial clock, a data line and a latch strobe. The strobe commits the word. The two low bits of the word route it to one of four setting registers. One register holds the monitor and channel-5/6 mode. Two registers hold the stepper-pair settings. The fourth holds either the bridge PWM settings or the third stepper settings, depending on the mode bit. The three serial wires and the three stepper step clocks are asynchronous to the block. Each passes through a synchronizer clocked by the system clock, and the block detects its edges there.

Not every field takes effect at the moment of the strobe. Each stepper field has one of three application times, and each stepper follows only its own step clock:
- **Immediate:** hold, reference level, monitor and PWM fields apply at the strobe.
- **Next step-clock rising edge:** reset and enable apply then.
- **Falling then rising edge:** direction and mode-select wait for a step-clock falling edge after the strobe, and then apply at the following rising edge.

The outputs show the settings as they currently apply to the downstream sequencers.

Top module: `motor_cfg_port`

## Requirements
- R1: Bits are sampled on serial-clock rising edges, bit 0 first. After eight bits, a strobe rising edge commits the word. Shifting without a strobe changes no output.
- R2: Word bits 1:0 pick the target: 00 mode register, 01 stepper 1, 10 stepper 2, 11 channel-5/6 register. Registers that are not picked keep their value.
- R3: The mode register output `mode_cfg_o` equals word bits 7:2 at the strobe. Bit 7 of the word (output bit 5) selects micro-step mode for channels 5/6.
- R4: Stepper word layout: bit 2 direction, bits 4:3 mode select, bit 5 hold, bit 6 reset (active low), bit 7 enable. The outputs carry word bits 7:2 as output bits 5:0. Hold applies at the strobe.
- R5: Stepper reset and enable apply at the first rising edge of that stepper's step clock after the strobe.
- R6: Stepper direction and mode select apply only at a step-clock rising edge that follows a step-clock falling edge seen after the strobe.
- R7: With micro-step mode set, the channel-5/6 word holds hold in bit 3 and the reference level in bits 7:6, and these apply at the strobe. Reset (bit 4) and enable (bit 5) apply on the next rising edge of step clock 3. Direction (bit 2) applies on a step-clock-3 rise that follows a fall.
- R8: With micro-step mode clear, every field of the channel-5/6 word (bridge direction and decay bits) applies at the strobe.
- R9: After system reset all outputs are zero.
- R10: Each stepper applies its deferred fields only on its own step clock. Edges on another stepper's clock leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, bit 0 first |
| ser_latch_i | input | 1 | Latch strobe, commits on rising edge |
| step_clk_i | input | 3 | Step clocks of steppers 1, 2, 3 (bit 0 = stepper 1) |
| mode_cfg_o | output | 6 | Mode register bits 7:2 |
| stp1_cfg_o | output | 6 | Applied stepper-1 word bits 7:2 |
| stp2_cfg_o | output | 6 | Applied stepper-2 word bits 7:2 |
| ch56_cfg_o | output | 6 | Applied channel-5/6 word bits 7:2 |

## Verification
A vector table writes each register address with words that have all upper bits set, and with mixed patterns. Each case checks that only the addressed output moves and that only the immediate fields show at the strobe. Directed sequences then drive step-clock rise, fall and rise after a write. These separate the rising-edge class from the falling-then-rising class. Edges on a foreign step clock confirm that each stepper follows only its own clock. The channel-5/6 register is written under both mode-bit values to show its two field layouts. A shifted word without a strobe must leave every output unchanged.

// File: rtl/motor_cfg_port.sv
module motor_cfg_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk_i,
  input  logic       ser_data_i,
  input  logic       ser_latch_i,
  input  logic [2:0] step_clk_i,
  output logic [5:0] mode_cfg_o,
  output logic [5:0] stp1_cfg_o,
  output logic [5:0] stp2_cfg_o,
  output logic [5:0] ch56_cfg_o
);
  localparam int NIN = 6;
  localparam logic [7:0] STP_IMM = 8'h20, STP_RT = 8'hC0, STP_DM = 8'h1C;
  localparam logic [7:0] MIC_IMM = 8'hC8, MIC_RT = 8'h30, MIC_DM = 8'h04;

  logic [NIN-1:0] sy [SYNC_STAGES+1];
  logic [NIN-1:0] now, prev;
  logic [7:0] shreg, cfg0;
  logic [7:0] shadow [3];
  logic [7:0] app [3];
  logic [7:0] app_nx [3];
  logic [7:0] imm_m [3], rt_m [3], dm_m [3];
  logic [2:0] pend_rt, pend_dm, fall_seen;
  logic       lat_micro;
  logic       sclk_rise, commit;
  logic [2:0] st_rise, st_fall;
  logic [1:0] sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= SYNC_STAGES; i++) sy[i] <= '0;
    end else begin
      sy[0] <= {step_clk_i, ser_latch_i, ser_data_i, ser_clk_i};
      for (int i = 1; i <= SYNC_STAGES; i++) sy[i] <= sy[i-1];
    end
  end

  assign now       = sy[SYNC_STAGES-1];
  assign prev      = sy[SYNC_STAGES];
  assign sclk_rise = now[0] & ~prev[0];
  assign commit    = now[2] & ~prev[2];
  assign st_rise   = now[5:3] & ~prev[5:3];
  assign st_fall   = ~now[5:3] & prev[5:3];
  assign sel       = shreg[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else if (sclk_rise) shreg <= {now[1], shreg[7:1]};
  end

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      imm_m[k] = STP_IMM;
      rt_m[k]  = STP_RT;
      dm_m[k]  = STP_DM;
    end
    imm_m[2] = cfg0[7] ? MIC_IMM : 8'hFC;
    rt_m[2]  = lat_micro ? MIC_RT : 8'h00;
    dm_m[2]  = lat_micro ? MIC_DM : 8'h00;
  end

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      logic [7:0] m;
      m = ((pend_rt[k] & st_rise[k]) ? rt_m[k] : 8'h00)
        | ((pend_dm[k] & fall_seen[k] & st_rise[k]) ? dm_m[k] : 8'h00);
      app_nx[k] = (app[k] & ~m) | (shadow[k] & m);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0      <= '0;
      lat_micro <= 1'b0;
      pend_rt   <= '0;
      pend_dm   <= '0;
      fall_seen <= '0;
      for (int k = 0; k < 3; k++) begin
        shadow[k] <= '0;
        app[k]    <= '0;
      end
    end else begin
      if (commit && sel == 2'b00) cfg0 <= shreg;
      if (commit && sel == 2'b11) lat_micro <= cfg0[7];
      for (int k = 0; k < 3; k++) begin
        if (commit && sel == 2'(k + 1)) begin
          shadow[k]    <= shreg;
          app[k]       <= (app[k] & ~imm_m[k]) | (shreg & imm_m[k]);
          pend_rt[k]   <= (k < 2) || cfg0[7];
          pend_dm[k]   <= (k < 2) || cfg0[7];
          fall_seen[k] <= 1'b0;
        end else begin
          app[k] <= app_nx[k];
          if (st_rise[k] && pend_rt[k]) pend_rt[k] <= 1'b0;
          if (st_rise[k] && pend_dm[k] && fall_seen[k]) begin
            pend_dm[k]   <= 1'b0;
            fall_seen[k] <= 1'b0;
          end else if (st_fall[k] && pend_dm[k]) begin
            fall_seen[k] <= 1'b1;
          end
        end
      end
    end
  end

  assign mode_cfg_o = cfg0[7:2];
  assign stp1_cfg_o = app[0][7:2];
  assign stp2_cfg_o = app[1][7:2];
  assign ch56_cfg_o = app[2][7:2];

  a_r1_shift_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shreg[6:0] == $past(shreg[7:1]));
  a_r3_mode_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_cfg_o) |-> $past(commit) && $past(sel) == 2'b00);
  a_r4_hold_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stp1_cfg_o[3]) |-> $past(commit) && $past(sel) == 2'b01);
  a_r5_rst_en_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stp1_cfg_o[5:4]) |-> $past(st_rise[0]));
  a_r6_dir_mode_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stp2_cfg_o[2:0]) |-> $past(st_rise[1]) && $past(fall_seen[1]));
  a_r10_own_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stp2_cfg_o[5:4]) |-> $past(st_rise[1]));
endmodule

// File: tb/motor_cfg_port_tb.sv
module motor_cfg_port_tb;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, slat = 0;
  logic [2:0] stc = '0;
  logic [5:0] mode_o, s1_o, s2_o, c56_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  motor_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
    .ser_latch_i(slat), .step_clk_i(stc), .mode_cfg_o(mode_o),
    .stp1_cfg_o(s1_o), .stp2_cfg_o(s2_o), .ch56_cfg_o(c56_o)
  );

  // word, mode, stepper1, stepper2, ch56
  localparam logic [31:0] VEC [6] = '{
    {8'hAC, 6'b101011, 6'b000000, 6'b000000, 6'b000000},
    {8'hFD, 6'b101011, 6'b001000, 6'b000000, 6'b000000},
    {8'hFE, 6'b101011, 6'b001000, 6'b001000, 6'b000000},
    {8'hFF, 6'b101011, 6'b001000, 6'b001000, 6'b110010},
    {8'h0C, 6'b000011, 6'b001000, 6'b001000, 6'b110010},
    {8'h77, 6'b000011, 6'b001000, 6'b001000, 6'b011101}
  };

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] w, bit latch);
    for (int i = 0; i < 8; i++) begin
      sdata = w[i];
      wait_n(6);
      sclk = 1;
      wait_n(6);
      sclk = 0;
    end
    wait_n(4);
    if (latch) begin
      slat = 1;
      wait_n(6);
      slat = 0;
    end
    wait_n(8);
  endtask

  task automatic step(int k, logic v);
    stc[k] = v;
    wait_n(8);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1;
    wait_n(2);
    chk("R9 mode", mode_o, 0);
    chk("R9 stp1", s1_o, 0);
    chk("R9 stp2", s2_o, 0);
    chk("R9 ch56", c56_o, 0);

    for (int v = 0; v < 6; v++) begin
      send(VEC[v][31:24], 1);
      chk($sformatf("R2/R3/R4/R8 vec%0d mode", v), mode_o, VEC[v][23:18]);
      chk($sformatf("R2/R4 vec%0d stp1", v), s1_o, VEC[v][17:12]);
      chk($sformatf("R2/R4 vec%0d stp2", v), s2_o, VEC[v][11:6]);
      chk($sformatf("R2/R7/R8 vec%0d ch56", v), c56_o, VEC[v][5:0]);
    end

    // R1: shift without strobe
    send(8'hE1, 0);
    chk("R1 no latch mode", mode_o, 6'b000011);
    chk("R1 no latch stp1", s1_o, 6'b001000);

    // R5, R6: stepper 1 timing classes
    send(8'hFD, 1);
    chk("R5 before edge", s1_o, 6'b001000);
    step(0, 1);
    chk("R5 rst/en on rise", s1_o, 6'b111000);
    step(0, 0);
    chk("R6 not on fall", s1_o, 6'b111000);
    step(0, 1);
    chk("R6 dir/mode on rise after fall", s1_o, 6'b111111);
    step(0, 0);

    // R10: foreign clock must not advance stepper 2
    send(8'h02, 1);
    chk("R4 hold cleared", s2_o, 6'b000000);
    send(8'hFE, 1);
    step(0, 1); step(0, 0); step(0, 1); step(2, 1); step(2, 0);
    chk("R10 stp2 ignores other clocks", s2_o, 6'b001000);
    step(1, 1);
    chk("R10 R5 stp2 own rise", s2_o, 6'b111000);
    step(1, 0); step(1, 1);
    chk("R10 R6 stp2 own fall+rise", s2_o, 6'b111111);
    chk("R10 stp1 untouched", s1_o, 6'b111111);
    step(0, 0); step(1, 0);

    // R7: micro mode on channel 5/6
    send(8'h00, 1);
    send(8'h03, 1);
    chk("R8 ch56 cleared", c56_o, 6'b000000);
    send(8'h80, 1);
    chk("R3 micro bit", mode_o, 6'b100000);
    send(8'hFF, 1);
    chk("R7 immediate hold/vref", c56_o, 6'b110010);
    step(2, 1);
    chk("R7 rst/en on rise", c56_o, 6'b111110);
    step(2, 0);
    chk("R7 dir not on fall", c56_o, 6'b111110);
    step(2, 1);
    chk("R7 dir on rise after fall", c56_o, 6'b111111);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule